// File: doc/BRIEF.md
# Vector Cryptography Operand Legality Checker

This block decides whether a vector cryptography instruction may issue with its current operands and vector state. It takes the destination index and one or two source indices, together with the element-group width and size, the active vector length, the start index and the signed LMUL exponent. It returns one `legal` flag and one error flag for each rule that fails. The rules are that register groups must not overlap, that vl and vstart must align to the element group, and that the register group must hold at least one element group.

The block is normally purely combinational. The `REG_OUT` parameter adds one output register stage, which gives one cycle of latency. With `SHA2_MODE` set, the checker applies the hash-family rule set. In that mode the group width comes from the element width, the group size is fixed at four elements, and both sources are tested against the destination. Decode, trap raising and the register file sit outside the block.

Top module: `vcrypt_legal_chk`

## Requirements
- R1: The register group span is 2 to the power `lmul_exp` when `lmul_exp` is above zero, and 1 when it is zero or negative.
- R2: `err_ovl_vs2` is 1 unless `vs2_idx + span <= vd_idx` or `vd_idx + span <= vs2_idx`. The indices are treated as unsigned 5-bit values and the sums are formed without wrap, so a source at 28 and a destination at 31 with span 8 clash.
- R3: In hash mode (`SHA2_MODE`=1), `err_ovl_vs1` applies the R2 rule to `vs1_idx` against `vd_idx`. In general mode, `err_ovl_vs1` stays 0 and `vs1_idx` has no effect on it.
- R4: `err_vl_align` is 1 exactly when `vl` is not a multiple of the group size. In general mode the group size is 2 to the power `egs_log2`, and in hash mode it is 4.
- R5: `err_vstart_align` is 1 exactly when `vstart` is not a multiple of that same group size.
- R6: When `lmul_exp` is 0 or more, `err_capacity` is 1 exactly when the group width exceeds `VLEN` shifted left by `lmul_exp`.
- R7: `lmul_exp` is a signed 3-bit two's-complement value. When it is negative, the capacity is `VLEN` shifted right by its magnitude, so 3'b111 means a right shift of one place and 3'b100 a right shift of four places.
- R8: `legal` is 1 exactly when all five error flags are 0.
- R9: With `REG_OUT`=1, every output shows the verdict for the inputs present at the previous rising clock edge, and all outputs are 0 while `rst` is high. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.
- R10: In hash mode, the group width is `sew` and the `egw` and `egs_log2` ports have no effect. In general mode, the group width is `egw` and `sew` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT=1 |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| vs1_idx | input | 5 | First source register index (checked in hash mode) |
| vs2_idx | input | 5 | Second source register index |
| vd_idx | input | 5 | Destination register index |
| lmul_exp | input | 3 | Signed LMUL exponent, -4..3 |
| sew | input | SEW_W | Element width, used as the group width in hash mode |
| egw | input | EGW_W | Element-group width in bits (general mode) |
| egs_log2 | input | 3 | Log2 of the element-group size (general mode) |
| vl | input | VL_W | Current vector length |
| vstart | input | VL_W | Current start element index |
| legal | output | 1 | Instruction may issue |
| err_ovl_vs1 | output | 1 | vs1 group overlaps vd group |
| err_ovl_vs2 | output | 1 | vs2 group overlaps vd group |
| err_vl_align | output | 1 | vl not a multiple of the group size |
| err_vstart_align | output | 1 | vstart not a multiple of the group size |
| err_capacity | output | 1 | Register group narrower than the group width |

## Verification
The properties assume that the inputs are stable across the sampling edge and, for the registered variant, that a full clock cycle has passed since reset was released before an output is compared with the delayed inputs. They also assume that `VLEN` is a power of two, so that the capacity bound of `VLEN` times eight is exact. The stimulus changes every input only on the falling edge and samples just after the rising edge, so both the combinational and the registered instances see the same held operands. The random vectors draw `lmul_exp` across the full signed range and group widths from 32 to 2048 bits. Directed vectors place register indices near 31 so that any wrapping sum would show up.

// File: rtl/vcl_pkg.sv
package vcl_pkg;

    localparam int unsigned IDX_W    = 5;
    localparam int unsigned SUM_W    = IDX_W + 1;
    localparam int unsigned LMUL_W   = 3;
    localparam int unsigned SPAN_W   = 4;
    localparam int unsigned EGSL_W   = 3;
    localparam int unsigned HASH_EGSL = 2;

    typedef logic [IDX_W-1:0]         vreg_idx_t;
    typedef logic signed [LMUL_W-1:0] lmul_exp_t;
    typedef logic [SPAN_W-1:0]        span_t;

    typedef struct packed {
        logic ovl_a;       // vs1 against vd
        logic ovl_b;       // vs2 against vd
        logic vl_mis;
        logic vstart_mis;
        logic cap_short;
    } vcl_fault_t;

    typedef struct packed {
        logic       ok;
        vcl_fault_t fault;
    } vcl_verdict_t;

    // Register-group span: only positive exponents widen the group.
    function automatic span_t grp_span(input lmul_exp_t e);
        if (e > 0)
            return span_t'(1) << e[LMUL_W-2:0];
        return span_t'(1);
    endfunction

endpackage

// File: rtl/vcl_overlap.sv
module vcl_overlap
    import vcl_pkg::*;
(
    input  vreg_idx_t src,
    input  vreg_idx_t dst,
    input  span_t     span,
    output logic      clash
);
    logic [SUM_W-1:0] src_w, dst_w, src_end, dst_end;

    // Widened by one bit so a high index plus span cannot wrap.
    assign src_w   = {1'b0, src};
    assign dst_w   = {1'b0, dst};
    assign src_end = src_w + SUM_W'(span);
    assign dst_end = dst_w + SUM_W'(span);

    assign clash = !((src_end <= dst_w) || (dst_end <= src_w));
endmodule

// File: rtl/vcl_align.sv
module vcl_align
    import vcl_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]      value,
    input  logic [EGSL_W-1:0] egs_log2,
    output logic              misaligned
);
    logic [W-1:0] low_mask;

    // Group size is a power of two, so divisibility is a low-bit test.
    assign low_mask   = (W'(1) << egs_log2) - W'(1);
    assign misaligned = |(value & low_mask);
endmodule

// File: rtl/vcl_capacity.sv
module vcl_capacity
    import vcl_pkg::*;
#(
    parameter int unsigned VLEN  = 128,
    parameter int unsigned EGW_W = 16
) (
    input  lmul_exp_t         lmul,
    input  logic [EGW_W-1:0]  grp_width,
    output logic              too_small
);
    localparam int unsigned CAP_W = $clog2(VLEN) + 4;
    localparam int unsigned CMP_W = (CAP_W > EGW_W) ? CAP_W : EGW_W;

    logic [CAP_W-1:0]  base;
    logic [LMUL_W-1:0] mag;
    logic [CAP_W-1:0]  cap;

    assign base = CAP_W'(VLEN);
    // Magnitude of the exponent; -4 maps to 4 in the unsigned view.
    assign mag  = lmul[LMUL_W-1] ? LMUL_W'(-lmul) : LMUL_W'(lmul);
    assign cap  = lmul[LMUL_W-1] ? (base >> mag) : (base << mag);

    assign too_small = CMP_W'(grp_width) > CMP_W'(cap);
endmodule

// File: rtl/vcl_stage.sv
module vcl_stage
    import vcl_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  vcl_verdict_t d,
    output vcl_verdict_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/vcrypt_legal_chk.sv
module vcrypt_legal_chk
    import vcl_pkg::*;
#(
    parameter int unsigned VLEN      = 128,
    parameter int unsigned VL_W      = 16,
    parameter int unsigned EGW_W     = 16,
    parameter int unsigned SEW_W     = 7,
    parameter bit          SHA2_MODE = 1'b0,
    parameter bit          REG_OUT   = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IDX_W-1:0]        vs1_idx,
    input  logic [IDX_W-1:0]        vs2_idx,
    input  logic [IDX_W-1:0]        vd_idx,
    input  logic signed [LMUL_W-1:0] lmul_exp,
    input  logic [SEW_W-1:0]        sew,
    input  logic [EGW_W-1:0]        egw,
    input  logic [EGSL_W-1:0]       egs_log2,
    input  logic [VL_W-1:0]         vl,
    input  logic [VL_W-1:0]         vstart,
    output logic                    legal,
    output logic                    err_ovl_vs1,
    output logic                    err_ovl_vs2,
    output logic                    err_vl_align,
    output logic                    err_vstart_align,
    output logic                    err_capacity
);
    localparam int unsigned NSRC = 2;

    // Mode-dependent operands
    logic [EGW_W-1:0]  eff_width;
    logic [EGSL_W-1:0] eff_egsl;
    span_t             span;

    assign eff_width = SHA2_MODE ? EGW_W'(sew) : egw;
    assign eff_egsl  = SHA2_MODE ? EGSL_W'(HASH_EGSL) : egs_log2;
    assign span      = grp_span(lmul_exp);

    // Overlap units, one per source; index 0 is vs1, index 1 is vs2
    vreg_idx_t  src_idx [NSRC];
    logic [NSRC-1:0] clash;

    assign src_idx[0] = vs1_idx;
    assign src_idx[1] = vs2_idx;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        vcl_overlap u_ovl (
            .src   (src_idx[gi]),
            .dst   (vd_idx),
            .span  (span),
            .clash (clash[gi])
        );
    end

    // Alignment of vl and vstart
    logic vl_mis, vs_mis;

    vcl_align #(.W(VL_W)) u_al_vl (
        .value      (vl),
        .egs_log2   (eff_egsl),
        .misaligned (vl_mis)
    );

    vcl_align #(.W(VL_W)) u_al_vstart (
        .value      (vstart),
        .egs_log2   (eff_egsl),
        .misaligned (vs_mis)
    );

    // Register group capacity
    logic cap_short;

    vcl_capacity #(.VLEN(VLEN), .EGW_W(EGW_W)) u_cap (
        .lmul      (lmul_exp),
        .grp_width (eff_width),
        .too_small (cap_short)
    );

    // Verdict assembly
    vcl_verdict_t verdict, verdict_q;

    always_comb begin
        verdict                  = '0;
        verdict.fault.ovl_a      = SHA2_MODE ? clash[0] : 1'b0;
        verdict.fault.ovl_b      = clash[1];
        verdict.fault.vl_mis     = vl_mis;
        verdict.fault.vstart_mis = vs_mis;
        verdict.fault.cap_short  = cap_short;
        verdict.ok               = ~|verdict.fault;
    end

    vcl_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (verdict),
        .q   (verdict_q)
    );

    assign legal            = verdict_q.ok;
    assign err_ovl_vs1      = verdict_q.fault.ovl_a;
    assign err_ovl_vs2      = verdict_q.fault.ovl_b;
    assign err_vl_align     = verdict_q.fault.vl_mis;
    assign err_vstart_align = verdict_q.fault.vstart_mis;
    assign err_capacity     = verdict_q.fault.cap_short;
endmodule

// File: rtl/vcl_legal_props.sv
module vcl_legal_props
    import vcl_pkg::*;
#(
    parameter int unsigned VLEN      = 128,
    parameter int unsigned VL_W      = 16,
    parameter int unsigned EGW_W     = 16,
    parameter int unsigned SEW_W     = 7,
    parameter bit          SHA2_MODE = 1'b0,
    parameter bit          REG_OUT   = 1'b0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [IDX_W-1:0]         vs1_idx,
    input logic [IDX_W-1:0]         vs2_idx,
    input logic [IDX_W-1:0]         vd_idx,
    input logic signed [LMUL_W-1:0] lmul_exp,
    input logic [SEW_W-1:0]         sew,
    input logic [EGW_W-1:0]         egw,
    input logic [EGSL_W-1:0]        egs_log2,
    input logic [VL_W-1:0]          vl,
    input logic [VL_W-1:0]          vstart,
    input logic                     legal,
    input logic                     err_ovl_vs1,
    input logic                     err_ovl_vs2,
    input logic                     err_vl_align,
    input logic                     err_vstart_align,
    input logic                     err_capacity
);
    // Inputs delayed by one edge, to line up with a registered output
    logic [IDX_W-1:0]         dly_vs1, dly_vs2, dly_vd;
    logic signed [LMUL_W-1:0] dly_lmul;
    logic [SEW_W-1:0]         dly_sew;
    logic [EGW_W-1:0]         dly_egw;
    logic [EGSL_W-1:0]        dly_egsl;
    logic [VL_W-1:0]          dly_vl, dly_vstart;
    logic                     seen;

    always_ff @(posedge clk) begin
        dly_vs1    <= vs1_idx;
        dly_vs2    <= vs2_idx;
        dly_vd     <= vd_idx;
        dly_lmul   <= lmul_exp;
        dly_sew    <= sew;
        dly_egw    <= egw;
        dly_egsl   <= egs_log2;
        dly_vl     <= vl;
        dly_vstart <= vstart;
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    logic [IDX_W-1:0]         s_vs1, s_vs2, s_vd;
    logic signed [LMUL_W-1:0] s_lmul;
    logic [VL_W-1:0]          s_vl, s_vstart;
    int                       s_width, s_grp;
    logic                     hold;

    assign s_vs1    = REG_OUT ? dly_vs1 : vs1_idx;
    assign s_vs2    = REG_OUT ? dly_vs2 : vs2_idx;
    assign s_vd     = REG_OUT ? dly_vd : vd_idx;
    assign s_lmul   = REG_OUT ? dly_lmul : lmul_exp;
    assign s_vl     = REG_OUT ? dly_vl : vl;
    assign s_vstart = REG_OUT ? dly_vstart : vstart;
    assign s_width  = SHA2_MODE ? int'(REG_OUT ? dly_sew : sew)
                                : int'(REG_OUT ? dly_egw : egw);
    assign s_grp    = SHA2_MODE ? 4 : (1 << (REG_OUT ? dly_egsl : egs_log2));
    assign hold     = REG_OUT && !seen;

    // R2
    same_reg_clash_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (s_vs2 == s_vd) |-> err_ovl_vs2);

    // R3
    vs1_clash_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (SHA2_MODE && (s_vs1 == s_vd)) |-> err_ovl_vs1);

    // R3
    vs1_quiet_chk: assert property (@(posedge clk) disable iff (rst || hold)
        !SHA2_MODE |-> !err_ovl_vs1);

    // R4
    vl_align_chk: assert property (@(posedge clk) disable iff (rst || hold)
        ((int'(s_vl) % s_grp) != 0) == err_vl_align);

    // R5
    vstart_align_chk: assert property (@(posedge clk) disable iff (rst || hold)
        ((int'(s_vstart) % s_grp) != 0) == err_vstart_align);

    // R6
    cap_bound_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (s_width > int'(VLEN) * 8) |-> err_capacity);

    // R6
    cap_unit_chk: assert property (@(posedge clk) disable iff (rst || hold)
        ((s_lmul == 0) && (s_width <= int'(VLEN))) |-> !err_capacity);

    // R8
    legal_clean_chk: assert property (@(posedge clk) disable iff (rst || hold)
        legal |-> !(err_ovl_vs1 || err_ovl_vs2 || err_vl_align || err_vstart_align || err_capacity));

    // R8
    legal_dirty_chk: assert property (@(posedge clk) disable iff (rst || hold)
        !legal |-> (err_ovl_vs1 || err_ovl_vs2 || err_vl_align || err_vstart_align || err_capacity));
endmodule

bind vcrypt_legal_chk vcl_legal_props #(
    .VLEN      (VLEN),
    .VL_W      (VL_W),
    .EGW_W     (EGW_W),
    .SEW_W     (SEW_W),
    .SHA2_MODE (SHA2_MODE),
    .REG_OUT   (REG_OUT)
) u_props (
    .clk              (clk),
    .rst              (rst),
    .vs1_idx          (vs1_idx),
    .vs2_idx          (vs2_idx),
    .vd_idx           (vd_idx),
    .lmul_exp         (lmul_exp),
    .sew              (sew),
    .egw              (egw),
    .egs_log2         (egs_log2),
    .vl               (vl),
    .vstart           (vstart),
    .legal            (legal),
    .err_ovl_vs1      (err_ovl_vs1),
    .err_ovl_vs2      (err_ovl_vs2),
    .err_vl_align     (err_vl_align),
    .err_vstart_align (err_vstart_align),
    .err_capacity     (err_capacity)
);

// File: tb/vcrypt_legal_chk_bench.sv
`timescale 1ns/1ps
module vcrypt_legal_chk_bench;
    localparam int VLEN = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        vs1, vs2, vd;
    logic signed [2:0] lmul;
    logic [6:0]        sew;
    logic [15:0]       egw;
    logic [2:0]        egsl;
    logic [15:0]       vl, vstart;

    logic g_legal, g_o1, g_o2, g_vl, g_vs, g_cap;
    logic h_legal, h_o1, h_o2, h_vl, h_vs, h_cap;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    // General mode, combinational
    vcrypt_legal_chk #(.VLEN(VLEN), .SHA2_MODE(1'b0), .REG_OUT(1'b0)) u_vcrypt_legal_chk (
        .clk(clk), .rst(rst), .vs1_idx(vs1), .vs2_idx(vs2), .vd_idx(vd),
        .lmul_exp(lmul), .sew(sew), .egw(egw), .egs_log2(egsl), .vl(vl), .vstart(vstart),
        .legal(g_legal), .err_ovl_vs1(g_o1), .err_ovl_vs2(g_o2),
        .err_vl_align(g_vl), .err_vstart_align(g_vs), .err_capacity(g_cap));

    // Hash mode, registered
    vcrypt_legal_chk #(.VLEN(VLEN), .SHA2_MODE(1'b1), .REG_OUT(1'b1)) u_vcrypt_legal_chk_sha (
        .clk(clk), .rst(rst), .vs1_idx(vs1), .vs2_idx(vs2), .vd_idx(vd),
        .lmul_exp(lmul), .sew(sew), .egw(egw), .egs_log2(egsl), .vl(vl), .vstart(vstart),
        .legal(h_legal), .err_ovl_vs1(h_o1), .err_ovl_vs2(h_o2),
        .err_vl_align(h_vl), .err_vstart_align(h_vs), .err_capacity(h_cap));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (vs1=%0d vs2=%0d vd=%0d lmul=%0d vl=%0d vstart=%0d)",
                     req, what, act, exp, vs1, vs2, vd, lmul, vl, vstart);
        end
    endtask

    function automatic bit clashes(int a, int d, int span);
        return !((a + span <= d) || (d + span <= a));
    endfunction

    // Returns {ovl_vs1, ovl_vs2, vl_mis, vstart_mis, cap_short}
    function automatic logic [4:0] model(bit hash);
        int lm, span, grp, width, cap;
        logic [4:0] r;
        lm    = int'(lmul);
        span  = (lm > 0) ? (1 << lm) : 1;                      // R1
        grp   = hash ? 4 : (1 << int'(egsl));
        width = hash ? int'(sew) : int'(egw);                  // R10
        cap   = (lm >= 0) ? (VLEN << lm) : (VLEN >> (-lm));    // R6, R7
        r[4]  = hash ? clashes(int'(vs1), int'(vd), span) : 1'b0;
        r[3]  = clashes(int'(vs2), int'(vd), span);
        r[2]  = (int'(vl) % grp) != 0;
        r[1]  = (int'(vstart) % grp) != 0;
        r[0]  = width > cap;
        return r;
    endfunction

    task automatic apply(input int a1, input int a2, input int d, input int lm,
                         input int sw, input int eg, input int gsl, input int vlv, input int vsv);
        logic [4:0] eg_exp, eh_exp;
        string cap_tag;
        @(negedge clk);
        vs1 = 5'(a1); vs2 = 5'(a2); vd = 5'(d); lmul = 3'(lm);
        sew = 7'(sw); egw = 16'(eg); egsl = 3'(gsl); vl = 16'(vlv); vstart = 16'(vsv);
        @(posedge clk);
        #1;
        eg_exp  = model(1'b0);
        eh_exp  = model(1'b1);
        cap_tag = (lmul < 0) ? "R7" : "R6";
        check("R3", "general ovl_vs1", g_o1, eg_exp[4]);
        check("R2", "general ovl_vs2", g_o2, eg_exp[3]);
        check("R4", "general vl_align", g_vl, eg_exp[2]);
        check("R5", "general vstart_align", g_vs, eg_exp[1]);
        check(cap_tag, "general capacity", g_cap, eg_exp[0]);
        check("R8", "general legal", g_legal, ~|eg_exp);
        // R9: registered instance holds the verdict of the inputs at the last edge
        check("R3", "hash ovl_vs1", h_o1, eh_exp[4]);
        check("R2", "hash ovl_vs2", h_o2, eh_exp[3]);
        check("R9", "hash vl_align", h_vl, eh_exp[2]);
        check("R5", "hash vstart_align", h_vs, eh_exp[1]);
        check("R10", "hash capacity", h_cap, eh_exp[0]);
        check("R8", "hash legal", h_legal, ~|eh_exp);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        vs1 = 5'd0; vs2 = 5'd8; vd = 5'd16; lmul = 3'sd0; sew = 7'd32;
        egw = 16'd32; egsl = 3'd2; vl = 16'd4; vstart = 16'd0;
        repeat (3) @(posedge clk);
        #1;
        // R9: registered outputs cleared under reset
        check("R9", "reset legal", h_legal, 1'b0);
        check("R9", "reset faults", |{h_o1, h_o2, h_vl, h_vs, h_cap}, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Fully legal operands, span 8
        apply(0, 8, 16, 3, 32, 128, 2, 8, 4);
        // R1: span 8 makes 8 and 15 clash; span 4 clears it
        apply(0, 8, 15, 3, 32, 128, 2, 8, 4);
        apply(0, 8, 15, 2, 32, 128, 2, 8, 4);
        // R1: negative exponent leaves span at 1, adjacent registers legal
        apply(4, 5, 6, -2, 32, 64, 2, 8, 4);
        // R7: fractional capacity 128>>2 = 32, widths 32 and 33
        apply(1, 5, 6, -2, 32, 32, 0, 3, 1);
        apply(1, 5, 6, -2, 32, 33, 0, 3, 1);
        // R7: most negative exponent, shift by four
        apply(1, 5, 6, -4, 8, 8, 0, 3, 1);
        apply(1, 5, 6, -4, 9, 9, 0, 3, 1);
        // R2: no wrap near the top of the index range
        apply(0, 28, 31, 3, 32, 128, 2, 8, 4);
        apply(0, 31, 28, 2, 32, 128, 2, 8, 4);
        apply(0, 24, 31, 3, 32, 128, 2, 8, 4);
        // R3: vs1 clash only matters in hash mode
        apply(16, 0, 16, 0, 32, 32, 2, 8, 4);
        // R4, R5: misaligned vl and vstart
        apply(0, 8, 16, 0, 32, 32, 2, 6, 2);
        apply(0, 8, 16, 0, 32, 32, 3, 16, 12);
        // R6: capacity edge at lmul 3 is 1024
        apply(0, 8, 16, 3, 64, 1024, 0, 1, 0);
        apply(0, 8, 16, 3, 64, 1025, 0, 1, 0);
        // R10: huge egw and odd group size do not affect hash mode
        apply(0, 8, 16, 0, 64, 65535, 7, 4, 8);
        // R10: large sew does not affect general mode
        apply(0, 8, 16, 0, 127, 32, 0, 3, 5);

        for (int i = 0; i < 400; i++) begin
            int lm, ew, vlv, vsv;
            lm  = int'($urandom_range(0, 7)) - 4;
            ew  = 32 << $urandom_range(0, 6);
            vlv = (($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                               : int'($urandom_range(0, 31)) * 8);
            vsv = (($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                               : int'($urandom_range(0, 31)) * 4);
            apply(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                  int'($urandom_range(0, 31)), lm,
                  ($urandom_range(0, 1) == 1) ? 64 : 32, ew,
                  int'($urandom_range(0, 4)), vlv, vsv);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule